// File: doc/BRIEF.md
# 8-bit ALU with Selective Status-Flag Update

This block is the arithmetic stage of a small 8-bit RISC core. A byte operation takes a destination operand, a source operand (a register value or an immediate, both presented on the same input), a 4-bit operation select and the current status byte. Within the same cycle it returns the result byte and the next status byte. Each operation rewrites only the flags it owns. The interrupt-enable and transfer bits always pass through unchanged.

A second path handles the word operations. It adds a 6-bit unsigned immediate to a 16-bit register pair, or subtracts the immediate from the pair, over two clock cycles. The low byte is formed on the first edge and the high byte together with the flags on the second. The core stalls on the busy output and takes the pair result when the done pulse arrives.

Status byte layout, bit 7 down to bit 0: I, T, H, S, V, N, Z, C. S always equals N XOR V for any operation that writes N or V.

Top module: `alu8_flags`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry-in taken from status bit 0) produce rd+rr(+C) mod 256. They write H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N (result bit 7), Z (result zero) and S.
- R2: Opcodes 2 (subtract) and 3 (subtract with borrow taken from status bit 0) produce rd-rr(-C) mod 256. They write H (borrow into bit 3), C (borrow out of bit 7), V, N, Z and S.
- R3: For opcode 3, Z is set only if the result is zero and Z was already set. It is never set from a clear state.
- R4: Opcodes 4 (AND), 5 (OR) and 6 (XOR) write only Z, N, S and V, with V forced to 0. H and C are kept.
- R5: Opcode 7 (one's complement) returns 0xFF-rd. It writes Z, N, V=0, S and C=1, and keeps H.
- R6: Opcode 8 (negate) returns 0x00-rd. It writes H, C (set when the result is nonzero), V (set when the result is 0x80), N, Z and S.
- R7: Opcodes 9 (increment) and 10 (decrement) write only Z, N, V and S. V is set when the result crosses to 0x80 for increment or to 0x7F for decrement. C and H are kept.
- R8: Opcode 11 returns 0xFF and leaves the status byte unchanged. Opcode 12 returns 0x00 and writes Z=1, N=0, V=0, S=0.
- R9: Status bits 7 and 6 are never modified. Opcodes 13 to 15 return rd and leave the status byte unchanged.
- R10: A word operation accepted on an edge (word_sub_i=0 add, 1 subtract; pair+K or pair-K mod 65536) raises word_done_o after exactly the next edge, for one cycle. The result is valid with it. Z, C, N, V and S are written from the 16-bit result; H, T and I are kept from the status byte sampled at acceptance.
- R11: word_go_i is ignored while word_busy_o is high. The pending operation completes with its own operands.
- R12: After reset, word_busy_o, word_done_o, word_res_o and word_sreg_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the word path |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Byte operation select |
| rd_i | input | 8 | Destination operand |
| rr_i | input | 8 | Source register or immediate |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Byte result |
| sreg_o | output | 8 | Next status byte for the byte operation |
| word_go_i | input | 1 | Start a word operation |
| word_sub_i | input | 1 | 1 selects pair minus immediate |
| pair_i | input | 16 | Register pair operand |
| kimm_i | input | 6 | Unsigned word immediate |
| word_busy_o | output | 1 | Word operation in its second cycle |
| word_done_o | output | 1 | One-cycle pulse with valid word result |
| word_res_o | output | 16 | Word result |
| word_sreg_o | output | 8 | Next status byte for the word operation |

## Verification
On every cycle the assertions check the flag-ownership rules: I and T pass through, set-register and reserved opcodes leave the status byte unchanged, and S follows N XOR V. They also check that logical operations clear V, that increment and decrement keep C, and that the with-borrow subtract never raises Z. Their cycle-level checks cover the word path's busy-then-done sequence. The numeric correctness of results, half-carry, overflow and borrow values, and the rejection of a second start while busy, are shown only by the bench's reference model across random and directed operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DW = 8;
    localparam int FW = 8;

    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_COM = 4'd7,
        OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_SER = 4'd11,
        OP_CLR = 4'd12, OP_R13 = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
    } alu_op_e;

    localparam logic [FW-1:0] M_ARITH = 8'b0011_1111;
    localparam logic [FW-1:0] M_CARRY = 8'b0001_1111;
    localparam logic [FW-1:0] M_LOGIC = 8'b0001_1110;
    localparam logic [FW-1:0] M_KEEP  = 8'b1100_0000;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [FW-1:0] flg;
        logic [FW-1:0] mask;
    } core_out_t;
endpackage

// File: rtl/alu_byte_core.sv
module alu_byte_core
    import alu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [FW-1:0] s,
    output core_out_t     o
);
    logic [DW:0]   ext;
    logic [DW-1:0] r;
    logic          cin;

    always_comb begin
        o      = '0;
        o.res  = a;
        o.flg  = s;
        ext    = '0;
        r      = '0;
        cin    = 1'b0;
        case (alu_op_e'(op))
            OP_ADD, OP_ADC: begin
                cin = (op == OP_ADC) ? s[F_C] : 1'b0;
                ext = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
                r   = ext[DW-1:0];
                o.flg[F_H] = (a[3] & b[3]) | (b[3] & ~r[3]) | (~r[3] & a[3]);
                o.flg[F_C] = (a[DW-1] & b[DW-1]) | (b[DW-1] & ~r[DW-1]) | (~r[DW-1] & a[DW-1]);
                o.flg[F_V] = (a[DW-1] & b[DW-1] & ~r[DW-1]) | (~a[DW-1] & ~b[DW-1] & r[DW-1]);
                o.flg[F_Z] = (r == '0);
                o.mask = M_ARITH;
            end
            OP_SUB, OP_SBC: begin
                cin = (op == OP_SBC) ? s[F_C] : 1'b0;
                ext = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
                r   = ext[DW-1:0];
                o.flg[F_H] = (~a[3] & b[3]) | (b[3] & r[3]) | (r[3] & ~a[3]);
                o.flg[F_C] = (~a[DW-1] & b[DW-1]) | (b[DW-1] & r[DW-1]) | (r[DW-1] & ~a[DW-1]);
                o.flg[F_V] = (a[DW-1] & ~b[DW-1] & ~r[DW-1]) | (~a[DW-1] & b[DW-1] & r[DW-1]);
                o.flg[F_Z] = (op == OP_SBC) ? ((r == '0) & s[F_Z]) : (r == '0);
                o.mask = M_ARITH;
            end
            OP_AND, OP_OR, OP_XOR: begin
                r = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
                o.flg[F_V] = 1'b0;
                o.flg[F_Z] = (r == '0);
                o.mask = M_LOGIC;
            end
            OP_COM: begin
                r = ~a;
                o.flg[F_V] = 1'b0;
                o.flg[F_C] = 1'b1;
                o.flg[F_Z] = (r == '0);
                o.mask = M_CARRY;
            end
            OP_NEG: begin
                r = '0 - a;
                o.flg[F_H] = r[3] | a[3];
                o.flg[F_C] = (r != '0);
                o.flg[F_V] = (r == {1'b1, {(DW-1){1'b0}}});
                o.flg[F_Z] = (r == '0);
                o.mask = M_ARITH;
            end
            OP_INC, OP_DEC: begin
                r = (op == OP_INC) ? a + 1'b1 : a - 1'b1;
                o.flg[F_V] = (op == OP_INC) ? (r == {1'b1, {(DW-1){1'b0}}})
                                            : (r == {1'b0, {(DW-1){1'b1}}});
                o.flg[F_Z] = (r == '0);
                o.mask = M_LOGIC;
            end
            OP_SER: begin
                r = '1;
                o.mask = '0;
            end
            OP_CLR: begin
                r = '0;
                o.flg[F_V] = 1'b0;
                o.flg[F_Z] = 1'b1;
                o.mask = M_LOGIC;
            end
            default: begin
                r = a;
                o.mask = '0;
            end
        endcase
        o.res      = r;
        o.flg[F_N] = r[DW-1];
        o.flg[F_S] = r[DW-1] ^ o.flg[F_V];
    end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
    import alu_pkg::*;
(
    input  logic [FW-1:0] old_s,
    input  logic [FW-1:0] new_s,
    input  logic [FW-1:0] mask,
    output logic [FW-1:0] s_out
);
    logic [FW-1:0] eff;

    always_comb begin
        eff   = mask & ~M_KEEP;
        s_out = (new_s & eff) | (old_s & ~eff);
    end
endmodule

// File: rtl/alu_word_seq.sv
module alu_word_seq
    import alu_pkg::*;
#(
    parameter int KW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            sub,
    input  logic [2*DW-1:0] pair,
    input  logic [KW-1:0]   k,
    input  logic [FW-1:0]   s,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] res,
    output logic [FW-1:0]   s_out
);
    localparam int PW = 2 * DW;

    typedef enum logic {PH_IDLE, PH_HI} phase_e;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] hi_op;
        logic [DW-1:0] lo_res;
        logic          cy;
        logic          sub;
        logic          p_msb;
        logic [FW-1:0] s_in;
        logic [PW-1:0] res;
        logic [FW-1:0] s_res;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    logic [DW:0]   lo_ext;
    logic [DW-1:0] hi_r;
    logic [PW-1:0] full;
    logic [FW-1:0] fl;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        lo_ext    = '0;
        hi_r      = '0;
        full      = '0;
        fl        = st_q.s_in;
        if (st_q.ph == PH_IDLE) begin
            if (go) begin
                lo_ext = sub ? ({1'b0, pair[DW-1:0]} - {{(DW+1-KW){1'b0}}, k})
                             : ({1'b0, pair[DW-1:0]} + {{(DW+1-KW){1'b0}}, k});
                st_d.lo_res = lo_ext[DW-1:0];
                st_d.cy     = lo_ext[DW];
                st_d.hi_op  = pair[PW-1:DW];
                st_d.p_msb  = pair[PW-1];
                st_d.sub    = sub;
                st_d.s_in   = s;
                st_d.ph     = PH_HI;
            end
        end else begin
            hi_r = st_q.sub ? st_q.hi_op - {{(DW-1){1'b0}}, st_q.cy}
                            : st_q.hi_op + {{(DW-1){1'b0}}, st_q.cy};
            full = {hi_r, st_q.lo_res};
            fl[F_C] = st_q.sub ? (full[PW-1] & ~st_q.p_msb) : (~full[PW-1] & st_q.p_msb);
            fl[F_V] = st_q.sub ? (~full[PW-1] & st_q.p_msb) : (full[PW-1] & ~st_q.p_msb);
            fl[F_N] = full[PW-1];
            fl[F_Z] = (full == '0);
            fl[F_S] = fl[F_N] ^ fl[F_V];
            st_d.res   = full;
            st_d.s_res = fl;
            st_d.done  = 1'b1;
            st_d.ph    = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.ph == PH_HI);
    assign done  = st_q.done;
    assign res   = st_q.res;
    assign s_out = st_q.s_res;
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu_pkg::*;
#(
    parameter int KW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_i,
    input  logic [DW-1:0]   rd_i,
    input  logic [DW-1:0]   rr_i,
    input  logic [FW-1:0]   sreg_i,
    output logic [DW-1:0]   res_o,
    output logic [FW-1:0]   sreg_o,
    input  logic            word_go_i,
    input  logic            word_sub_i,
    input  logic [2*DW-1:0] pair_i,
    input  logic [KW-1:0]   kimm_i,
    output logic            word_busy_o,
    output logic            word_done_o,
    output logic [2*DW-1:0] word_res_o,
    output logic [FW-1:0]   word_sreg_o
);
    core_out_t core_o;

    alu_byte_core u_core (
        .op (op_i),
        .a  (rd_i),
        .b  (rr_i),
        .s  (sreg_i),
        .o  (core_o)
    );

    alu_flag_merge u_merge (
        .old_s (sreg_i),
        .new_s (core_o.flg),
        .mask  (core_o.mask),
        .s_out (sreg_o)
    );

    assign res_o = core_o.res;

    alu_word_seq #(.KW(KW)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (word_go_i),
        .sub   (word_sub_i),
        .pair  (pair_i),
        .k     (kimm_i),
        .s     (sreg_i),
        .busy  (word_busy_o),
        .done  (word_done_o),
        .res   (word_res_o),
        .s_out (word_sreg_o)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_i,
    input logic [7:0] sreg_i,
    input logic [7:0] res_o,
    input logic [7:0] sreg_o,
    input logic       word_go_i,
    input logic       word_busy_o,
    input logic       word_done_o,
    input logic [7:0] word_sreg_o
);
    // R9
    it_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_o[7:6] == sreg_i[7:6]);

    // R8
    ser_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11) |-> (res_o == 8'hFF && sreg_o == sreg_i));

    // R9
    reserved_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd13) |-> (sreg_o == sreg_i));

    // R1
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd10 || op_i == 4'd12) |-> (sreg_o[4] == (sreg_o[2] ^ sreg_o[3])));

    // R4
    logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd4 && op_i <= 4'd6) |-> (!sreg_o[3] && sreg_o[0] == sreg_i[0]));

    // R7
    incdec_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9 || op_i == 4'd10) |-> (sreg_o[0] == sreg_i[0] && sreg_o[5] == sreg_i[5]));

    // R3
    sbc_z_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3 && !sreg_i[1]) |-> !sreg_o[1]);

    // R10
    word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_go_i && !word_busy_o) |=> (word_busy_o ##1 word_done_o));

    // R10
    word_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_done_o) |-> $past(word_busy_o));

    // R10
    word_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |=> !word_done_o);

    // R10
    word_s_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |-> (word_sreg_o[4] == (word_sreg_o[2] ^ word_sreg_o[3])));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .sreg_i      (sreg_i),
    .res_o       (res_o),
    .sreg_o      (sreg_o),
    .word_go_i   (word_go_i),
    .word_busy_o (word_busy_o),
    .word_done_o (word_done_o),
    .word_sreg_o (word_sreg_o)
);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  rd_i = '0;
    logic [7:0]  rr_i = '0;
    logic [7:0]  sreg_i = '0;
    logic [7:0]  res_o;
    logic [7:0]  sreg_o;
    logic        word_go_i = 1'b0;
    logic        word_sub_i = 1'b0;
    logic [15:0] pair_i = '0;
    logic [5:0]  kimm_i = '0;
    logic        word_busy_o;
    logic        word_done_o;
    logic [15:0] word_res_o;
    logic [7:0]  word_sreg_o;

    int n_chk = 0;
    int n_bad = 0;
    int seed_v;

    always #4 clk = ~clk;

    alu8_flags u0 (.*);

    function automatic string req_of(input int op);
        case (op)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R2/R3";
            4, 5, 6: return "R4";
            7:       return "R5";
            8:       return "R6";
            9, 10:   return "R7";
            11, 12:  return "R8";
            default: return "R9";
        endcase
    endfunction

    // returns {result, status}
    function automatic logic [15:0] ref_byte(input int op, input int a, input int b, input logic [7:0] s);
        int r, sa, sb, sr, c;
        logic h, cf, v, z, upd_z;
        logic [7:0] m, f;
        r = a; m = 8'h00; h = 0; cf = 0; v = 0; upd_z = 1;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        c  = s[0];
        case (op)
            0, 1: begin
                if (op == 0) c = 0;
                r = a + b + c; cf = (r > 255);
                h = ((a % 16) + (b % 16) + c) > 15;
                sr = sa + sb + c; v = (sr > 127) || (sr < -128);
                m = 8'h3F;
            end
            2, 3: begin
                if (op == 2) c = 0;
                r = a - b - c; cf = (a < b + c);
                h = (a % 16) < ((b % 16) + c);
                sr = sa - sb - c; v = (sr > 127) || (sr < -128);
                m = 8'h3F;
            end
            4: begin r = a & b; m = 8'h1E; end
            5: begin r = a | b; m = 8'h1E; end
            6: begin r = a ^ b; m = 8'h1E; end
            7: begin r = 255 - a; cf = 1; m = 8'h1F; end
            8: begin r = 0 - a; cf = (a != 0); h = (a % 16) != 0; v = (a == 128); m = 8'h3F; end
            9: begin r = a + 1; v = (sa + 1 > 127); m = 8'h1E; end
            10: begin r = a - 1; v = (sa - 1 < -128); m = 8'h1E; end
            11: begin r = 255; m = 8'h00; end
            12: begin r = 0; m = 8'h1E; end
            default: begin r = a; m = 8'h00; end
        endcase
        r = r & 255;
        z = (r == 0);
        if (op == 3) z = z && s[1];
        f = {2'b00, h, (r > 127) ^ v, v, (r > 127), z, cf};
        return {r[7:0], (f & m) | (s & ~m)};
    endfunction

    function automatic logic [23:0] ref_word(input logic sub, input int p, input int k, input logic [7:0] s);
        int r, sp;
        logic cf, v, n, z;
        sp = (p > 32767) ? p - 65536 : p;
        if (sub) begin
            r = p - k; cf = (k > p); v = (sp - k < -32768);
        end else begin
            r = p + k; cf = (r > 65535); v = (sp + k > 32767);
        end
        r = r & 65535;
        n = (r > 32767); z = (r == 0);
        return {r[15:0], s[7:5], n ^ v, v, n, z, cf};
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic byte_vec(input int op, input int a, input int b, input logic [7:0] s);
        logic [15:0] e;
        @(negedge clk);
        op_i = op[3:0]; rd_i = a[7:0]; rr_i = b[7:0]; sreg_i = s;
        #2;
        e = ref_byte(op, a, b, s);
        check(req_of(op), {8'h00, res_o, sreg_o}, {8'h00, e});
    endtask

    task automatic word_vec(input logic sub, input int p, input int k, input logic [7:0] s);
        logic [23:0] e;
        @(negedge clk);
        word_go_i = 1'b1; word_sub_i = sub; pair_i = p[15:0]; kimm_i = k[5:0]; sreg_i = s;
        @(negedge clk);
        // R11: a second request presented while busy must be dropped
        word_sub_i = ~sub; pair_i = ~p[15:0]; kimm_i = ~k[5:0]; sreg_i = ~s;
        check("R11 busy", {23'h0, word_busy_o}, 24'h1);
        @(negedge clk);
        word_go_i = 1'b0;
        e = ref_word(sub, p, k, s);
        check("R10 done", {23'h0, word_done_o}, 24'h1);
        check("R10/R11 word", {word_res_o, word_sreg_o}, e);
        @(negedge clk);
        check("R10 pulse", {23'h0, word_done_o}, 24'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        seed_v = $urandom(32'h5EED_0A1B);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 reset", {word_busy_o, word_done_o, 6'h0, word_res_o}, 24'h0);
        check("R12 reset sreg", {16'h0, word_sreg_o}, 24'h0);
        rst_n = 1'b1;

        // directed corners
        byte_vec(0, 8'h0F, 8'h01, 8'h00);   // R1 half carry
        byte_vec(0, 8'h7F, 8'h01, 8'hC0);   // R1 overflow, I/T kept
        byte_vec(0, 8'hFF, 8'h01, 8'h00);   // R1 carry and zero
        byte_vec(1, 8'hFF, 8'h00, 8'h01);   // R1 carry-in
        byte_vec(2, 8'h10, 8'h01, 8'h00);   // R2 half borrow
        byte_vec(2, 8'h80, 8'h01, 8'h00);   // R2 overflow
        byte_vec(3, 8'h00, 8'h00, 8'h01);   // R2 borrow-in
        byte_vec(3, 8'h05, 8'h05, 8'h00);   // R3 zero result, Z clear stays clear
        byte_vec(3, 8'h05, 8'h05, 8'h02);   // R3 zero result, Z set stays set
        byte_vec(4, 8'hF0, 8'h0F, 8'h2D);   // R4 V cleared, H and C kept
        byte_vec(7, 8'hFF, 8'h00, 8'h00);   // R5
        byte_vec(8, 8'h80, 8'h00, 8'h00);   // R6 0x80
        byte_vec(8, 8'h00, 8'h00, 8'h3F);   // R6 zero
        byte_vec(9, 8'h7F, 8'h00, 8'h21);   // R7 inc overflow, C/H kept
        byte_vec(10, 8'h80, 8'h00, 8'h01);  // R7 dec overflow
        byte_vec(11, 8'h12, 8'h34, 8'hA5);  // R8 set
        byte_vec(12, 8'h12, 8'h34, 8'hFF);  // R8 clear
        byte_vec(14, 8'h5A, 8'h00, 8'h3C);  // R9 reserved

        word_vec(1'b0, 16'hFFC1, 63, 8'h20);  // R10 add carry out, zero
        word_vec(1'b0, 16'h7FFF, 1, 8'h00);   // R10 add overflow
        word_vec(1'b1, 16'h0000, 1, 8'hC0);   // R10 sub borrow
        word_vec(1'b1, 16'h8000, 1, 8'h00);   // R10 sub overflow
        word_vec(1'b1, 16'h0100, 0, 8'h00);   // R10 zero immediate

        // constrained random byte operations
        for (int i = 0; i < 4000; i++) begin
            byte_vec(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                     int'($urandom_range(0, 255)), 8'($urandom));
        end
        // constrained random word operations
        for (int i = 0; i < 300; i++) begin
            word_vec(1'($urandom), int'($urandom_range(0, 65535)),
                     int'($urandom_range(0, 63)), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule